// File: doc/BRIEF.md
# Vertical 8-tap tile filter

This block applies a vertical 8-tap FIR filter to a strip four pixels wide and returns the result as 4x4 tiles of 8-bit pixels. Each input row carries four 8-bit pixels packed into 32 bits. For each tile the upstream logic sends eleven consecutive rows. That is the four output rows plus the seven extra rows that the taps need. The first row sent lies three rows above the first output row.

The four columns are filtered in parallel. When the row window is full enough for an output row, the block presents that row on its output port. Every output pixel is computed as follows:

- The pixel values are zero-extended.
- Each is multiplied by one of eight signed 16-bit coefficients.
- The products are summed in 32 bits.
- The sum gets 64 added and is shifted arithmetically right by seven.
- The result is clamped to the range 0..255.

A one-cycle `tile_start` pulse clears the window so that the next tile can begin. The coefficients are loaded one tap at a time through a small write port, normally between tiles. The caller handles frame addressing and tile ordering, which go 4 columns across a strip and then 4 rows down.

Top module: `vtap8_tile`

## Requirements
- R1: After reset, and in the cycle after a `tile_start` pulse, `out_valid` and `tile_done` are low and `in_ready` is high. A pulse in the middle of a tile discards the rows already received.
- R2: `in_ready` is low during a `tile_start` cycle. It is also low once eleven rows of the current tile have been accepted, and it stays low until the next `tile_start`. While it is low, `in_valid` has no effect on any later output.
- R3: Output row j (j = 0..3) is valid exactly when at least 8+j rows of the tile have been accepted and rows 0..j-1 have been taken. Pixel c sits in bits [8c+7:8c] of a row. Before rounding, output pixel c of row j equals the sum over k of coef[k] times input row j+k, pixel c, with the pixel zero-extended.
- R4: Rounding adds 64 to the 32-bit sum and then shifts it right arithmetically by 7, so the result is the floor of (sum+64)/128.
- R5: A rounded value below 0 gives an output of 0, and one above 255 gives an output of 255.
- R6: Output rows are emitted top row first. While `out_valid` is high and `out_ready` is low, `out_row` stays unchanged, provided no coefficient write or `tile_start` occurs.
- R7: `tile_done` is high exactly when the fourth output row (j = 3) is valid.
- R8: When `coef_we` is high, the signed value `coef_data` is written to tap `coef_idx`. Tap 0 weights the first (topmost) row of the window and tap 7 the last. Reset clears all taps to 0.
- R9: Once the four rows of a tile have been taken, `out_valid` stays low until the next `tile_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 3 | Tap number to write |
| coef_data | input | 16 | Signed coefficient value |
| tile_start | input | 1 | Clears the row window for a new tile |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Block can accept an input row |
| in_row | input | 32 | Four input pixels, pixel c at bits [8c+7:8c] |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Downstream takes the output row |
| out_row | output | 32 | Four filtered pixels, same packing as the input |
| tile_done | output | 1 | Marks the last output row of a tile |

## Verification
Each coefficient set tests a different part of the function:

- A single centred tap of 128 turns the filter into a pure three-row delay, which exposes errors in window alignment.
- A single tap of 128 placed first or last exposes a reversed tap order.
- Random sets that sum to 128, with random input gaps and output stalls, test the full datapath under back-pressure.
- Single small taps of +1 and -1 on chosen pixel values land on rounding boundaries. They show whether the offset is missing and whether the shift is logical or arithmetic.
- Large positive and negative taps on full-scale pixels drive both saturation limits.

Further runs check that a tile aborted with `tile_start` leaves no trace. They also check that rows offered after the eleventh are ignored.

// File: rtl/vtap8_tile.sv
module vtap8_tile #(
  parameter int PIX_W  = 8,
  parameter int COLS   = 4,
  parameter int TAPS   = 8,
  parameter int COEF_W = 16,
  parameter int TILE_H = 4,
  parameter int SHIFT  = 7,
  parameter int ACC_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      coef_we,
  input  logic [$clog2(TAPS)-1:0]   coef_idx,
  input  logic [COEF_W-1:0]         coef_data,
  input  logic                      tile_start,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [PIX_W*COLS-1:0]     in_row,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [PIX_W*COLS-1:0]     out_row,
  output logic                      tile_done
);

  localparam int ROWS  = TILE_H + TAPS - 1;
  localparam int ROW_W = PIX_W * COLS;
  localparam int CNT_W = $clog2(ROWS + 1);
  localparam int OIX_W = $clog2(TILE_H + 1);
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic [CNT_W-1:0]         cnt;
  logic [OIX_W-1:0]         oidx;
  logic [OIX_W-1:0]         base;
  logic [ROW_W-1:0]         rowbuf [ROWS];
  logic signed [COEF_W-1:0] coef   [TAPS];

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;

  assign in_ready  = !tile_start && (cnt < CNT_W'(ROWS));
  assign out_valid = (oidx < OIX_W'(TILE_H)) && (int'(cnt) >= int'(oidx) + TAPS);
  assign tile_done = out_valid && (oidx == OIX_W'(TILE_H - 1));
  assign base      = out_valid ? oidx : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      oidx <= '0;
    end else if (tile_start) begin
      cnt  <= '0;
      oidx <= '0;
    end else begin
      if (in_fire)  cnt  <= cnt + 1'b1;
      if (out_fire) oidx <= oidx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) rowbuf[cnt] <= in_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) coef[k] <= '0;
    end else if (coef_we) begin
      coef[coef_idx] <= coef_data;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rnd;

    always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++)
        acc = acc + $signed({{(ACC_W-PIX_W){1'b0}}, rowbuf[int'(base) + k][c*PIX_W +: PIX_W]})
                    * ACC_W'(coef[k]);
      rnd = (acc + ACC_W'(1 <<< (SHIFT - 1))) >>> SHIFT;
    end

    assign out_row[c*PIX_W +: PIX_W] = rnd[ACC_W-1]          ? '0 :
                                       (rnd > ACC_W'(PMAX))  ? PIX_W'(PMAX) :
                                                               rnd[PIX_W-1:0];
  end

endmodule

// File: rtl/vtap8_tile_chk.sv
module vtap8_tile_chk #(
  parameter int TAPS   = 8,
  parameter int TILE_H = 4,
  parameter int ROW_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coef_we,
  input logic             tile_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ROW_W-1:0] out_row,
  input logic             tile_done
);
  localparam int ROWS = TILE_H + TAPS - 1;

  int rows_seen;
  int outs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || tile_start) begin
      rows_seen <= 0;
      outs_seen <= 0;
    end else begin
      if (in_valid && in_ready)   rows_seen <= rows_seen + 1;
      if (out_valid && out_ready) outs_seen <= outs_seen + 1;
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tile_start |=> !out_valid && !tile_done && in_ready);

  p_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tile_start |-> !in_ready);

  p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> rows_seen < ROWS);

  p_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rows_seen >= outs_seen + TAPS);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !tile_start && !coef_we) |=> out_valid && $stable(out_row));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |-> out_valid && outs_seen == TILE_H - 1);

  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> outs_seen < TILE_H);

endmodule

bind vtap8_tile vtap8_tile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .tile_start(tile_start),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_row(out_row), .tile_done(tile_done)
);

// File: tb/vtap8_tile_tb_top.sv
`timescale 1ns/1ps
module vtap8_tile_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        coef_we = 0;
  logic [2:0]  coef_idx = 0;
  logic [15:0] coef_data = 0;
  logic        tile_start = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_row = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] out_row;
  logic        tile_done;

  always #2 clk = ~clk;

  vtap8_tile dut_i (.*);

  int    checks = 0, fails = 0;
  string tag = "R3";
  bit    stall_mode = 0;

  int          mcoef [8];
  logic [31:0] mrows [11];
  int          rows_acc = 0, outs = 0;
  logic [31:0] trows [11];

  function automatic logic [31:0] ref_row(int j);
    logic [31:0] r;
    for (int c = 0; c < 4; c++) begin
      int s = 0;
      for (int k = 0; k < 8; k++) s += int'(mrows[j+k][c*8 +: 8]) * mcoef[k];
      s = (s + 64) >>> 7;
      r[c*8 +: 8] = (s < 0) ? 8'd0 : (s > 255) ? 8'd255 : 8'(s);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // cycle-by-cycle reference model, sampled away from the clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rows_acc = 0; outs = 0;
      for (int k = 0; k < 8; k++) mcoef[k] = 0;
    end else begin
      bit exp_ready, exp_valid;
      exp_ready = (rows_acc < 11) && !tile_start;
      exp_valid = (outs < 4) && (rows_acc >= outs + 8);
      check((rows_acc == 0) ? "R1" : "R2", 32'(in_ready), 32'(exp_ready));
      check((outs == 4) ? "R9" : "R3", 32'(out_valid), 32'(exp_valid));
      check("R7", 32'(tile_done), 32'(exp_valid && outs == 3));
      if (exp_valid) check(tag, out_row, ref_row(outs));
      if (coef_we) mcoef[coef_idx] = int'($signed(coef_data));
      if (tile_start) begin
        rows_acc = 0; outs = 0;
      end else begin
        if (in_valid && exp_ready) begin mrows[rows_acc] = in_row; rows_acc++; end
        if (exp_valid && out_ready) outs++;
      end
    end
  end

  always begin
    @(posedge clk); #1;
    out_ready = stall_mode ? ($urandom % 3 == 0) : 1'b1;
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic load_coefs(input int c [8]);
    for (int k = 0; k < 8; k++) begin
      coef_we = 1; coef_idx = 3'(k); coef_data = 16'(c[k]); tick();
    end
    coef_we = 0;
  endtask

  task automatic feed_rows(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      bit acc;
      while (gaps && ($urandom % 3 == 0)) begin in_valid = 0; tick(); end
      in_valid = 1; in_row = trows[i];
      do begin @(negedge clk); acc = in_ready; @(posedge clk); #1; end while (!acc);
      in_valid = 0;
    end
  endtask

  task automatic run_tile(input bit gaps);
    tile_start = 1; tick(); tile_start = 0;
    feed_rows(11, gaps);
    while (outs < 4) tick();
    in_valid = 1; in_row = $urandom;   // ignored: window is full (R2, R9)
    repeat (3) tick();
    in_valid = 0;
  endtask

  task automatic rand_rows;
    for (int i = 0; i < 11; i++) trows[i] = $urandom;
  endtask

  task automatic one_tap(input int pos, input int val);
    int c [8];
    for (int k = 0; k < 8; k++) c[k] = (k == pos) ? val : 0;
    load_coefs(c);
  endtask

  initial begin
    int c [8];
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    check("R1", 32'(in_ready), 32'd1);
    check("R1", 32'(out_valid), 32'd0);
    check("R1", 32'(tile_done), 32'd0);
    tick();

    tag = "R3"; one_tap(3, 128);
    repeat (3) begin rand_rows(); run_tile(0); end

    tag = "R8"; one_tap(0, 128); rand_rows(); run_tile(1);
    one_tap(7, 128); rand_rows(); run_tile(1);

    tag = "R1"; one_tap(2, 128); rand_rows();
    tile_start = 1; tick(); tile_start = 0;
    feed_rows(9, 1);
    rand_rows(); run_tile(0);

    tag = "R6"; stall_mode = 1;
    repeat (12) begin
      int s = 0;
      for (int k = 0; k < 7; k++) begin c[k] = int'($urandom % 121) - 40; s += c[k]; end
      c[7] = 128 - s;
      load_coefs(c); rand_rows(); run_tile(1);
    end
    stall_mode = 0;

    tag = "R4";
    for (int i = 0; i < 11; i++) trows[i] = {8'd192, 8'd191, 8'd64, 8'd63};
    one_tap(0, 1);  run_tile(0);
    one_tap(0, -1); run_tile(0);
    for (int i = 0; i < 11; i++) trows[i] = {8'd65, 8'd255, 8'd128, 8'd1};
    one_tap(0, -1); run_tile(0);
    one_tap(4, 3);  run_tile(0);

    tag = "R5";
    for (int i = 0; i < 11; i++) trows[i] = 32'hFFFF_FFFF;
    one_tap(0, 2000);  run_tile(0);
    one_tap(0, -2000); run_tile(0);
    for (int k = 0; k < 8; k++) c[k] = (k % 2) ? 32767 : -32768;
    load_coefs(c);
    repeat (3) begin rand_rows(); run_tile(1); end

    repeat (4) tick();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule